// File: doc/BRIEF.md
# Linked-List Hardware Queue Manager

This block keeps a set of hardware queues. Each queue holds descriptor addresses, and every queue is a singly linked list. All the lists are threaded through one shared link RAM, whose entries hold next-index values. Callers only ever deal in full descriptor addresses. On a push, the block turns the address into a link index through a small table of programmable memory regions. On a pop, it turns the index back into an address through the same table.

For each queue the block keeps a head index, a tail index and an entry count. It drives one pending line per queue, and it returns the entry count of any selected queue. Each memory region is programmed with four values:
- a 16-byte-aligned base address;
- the first link index it owns;
- its descriptor size, as a power-of-two multiple of 16 bytes and at least 32;
- its descriptor count, as a power of two and at least 32.

A region table entry must not overlap another region, in address or in link index. Keeping them apart is the programmer's duty.

Top module: `qm_queue_mgr`

## Requirements
- R1: After reset every queue is empty. Every count reads 0, `q_pending` is all zero, `push_err` is 0, `pop_valid` is 0, and no region is valid, so any push is rejected.
- R2: A region write (`cfg_we`) takes effect only if all three conditions hold: `cfg_base[3:0]` is 0, `cfg_size_log2` is at least 1 (descriptor size = 16 << cfg_size_log2 bytes), and `cfg_count_log2` is between 5 and 8 (count = 1 << cfg_count_log2). Any other write leaves that region as it was.
- R3: A push of address base + k*size with k < count, in a valid region, links index start + k to the tail of `push_queue`. The queue's count rises by one from the clock edge that samples the push.
- R4: A push whose address falls in no valid region, or is not on a descriptor boundary, changes no queue. It sets `push_err` from the next edge, and `push_err` stays high until reset.
- R5: One cycle after `pop_en` is sampled, `pop_valid` is high for exactly one cycle. `pop_addr` then carries the oldest address of `pop_queue`, converted back through its region, and the count drops by one.
- R6: A pop of an empty queue gives `pop_valid` with `pop_addr` = 0 and changes no count.
- R7: `q_pending[n]` is high exactly when queue n holds at least one entry.
- R8: `cnt_value` shows, without delay, the registered entry count of the queue chosen by `cnt_queue`.
- R9: A push and a pop to the same queue in one cycle act as push-then-pop. On an empty queue the pop returns the pushed address and the queue stays empty. On a one-entry queue the pop returns the old entry and the count stays 1.
- R10: Queues share the link RAM without interfering. Pushes interleaved across queues and across regions come back from each queue in that queue's own push order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Region table write strobe |
| cfg_sel | input | 2 | Region number to write |
| cfg_base | input | 32 | Region base address |
| cfg_start | input | 8 | First link index of the region |
| cfg_size_log2 | input | 3 | Descriptor size = 16 << value bytes |
| cfg_count_log2 | input | 4 | Descriptor count = 1 << value |
| push_en | input | 1 | Push request |
| push_queue | input | 6 | Queue to push to |
| push_addr | input | 32 | Descriptor address to push |
| pop_en | input | 1 | Pop request |
| pop_queue | input | 6 | Queue to pop from |
| pop_valid | output | 1 | Pop result valid, one cycle after the request |
| pop_addr | output | 32 | Popped descriptor address, 0 if the queue was empty |
| cnt_queue | input | 6 | Queue whose count is shown |
| cnt_value | output | 9 | Entry count of the selected queue |
| q_pending | output | 64 | One non-empty flag per queue |
| push_err | output | 1 | Sticky rejected-push flag |

## Verification
Every result arrives on a fixed schedule:
- Pop results and the error flag are registered, so they appear in the cycle after the edge that samples the request.
- Counts and pending flags change at that same edge.
- `cnt_value` follows `cnt_queue` with no delay.

The bench drives inputs at the falling edge. It reads pop results, the error flag and counts at the next falling edge, after exactly one rising edge. Count reads take place a short delay after `cnt_queue` is changed. Same-cycle push and pop are driven in a single cycle, so the push-first ordering is exercised exactly.

// File: rtl/qm_pkg.sv
package qm_pkg;
    localparam int QM_ADDR_W = 32;
    localparam int QM_IDX_W  = 8;
    localparam int QM_SZ_W   = 3;
    localparam int QM_CL_W   = 4;
    localparam int QM_CL_MIN = 5;

    typedef struct packed {
        logic                 vld;
        logic [QM_ADDR_W-1:0] base;
        logic [QM_IDX_W-1:0]  start;
        logic [QM_SZ_W-1:0]   sz_log2;
        logic [QM_CL_W-1:0]   cnt_log2;
    } qm_region_t;
endpackage

// File: rtl/qm_link_ram.sv
module qm_link_ram #(
    parameter int DEPTH = 256,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/qm_addr_enc.sv
module qm_addr_enc
    import qm_pkg::*;
#(
    parameter int NUM_REG = 4
) (
    input  qm_region_t [NUM_REG-1:0] rgn,
    input  logic [QM_ADDR_W-1:0]     addr,
    output logic                     hit,
    output logic [QM_IDX_W-1:0]      idx
);
    logic [NUM_REG-1:0]               match;
    logic [NUM_REG-1:0][QM_IDX_W-1:0] ridx;

    for (genvar r = 0; r < NUM_REG; r++) begin : g_rgn
        logic [4:0]           sh;
        logic [QM_ADDR_W-1:0] off, span, mask;
        always_comb begin
            sh   = 5'(rgn[r].sz_log2) + 5'd4;
            off  = addr - rgn[r].base;
            span = QM_ADDR_W'(1) << (sh + 5'(rgn[r].cnt_log2));
            mask = (QM_ADDR_W'(1) << sh) - QM_ADDR_W'(1);
            match[r] = rgn[r].vld && (addr >= rgn[r].base) && (off < span)
                       && ((off & mask) == '0);
            ridx[r]  = rgn[r].start + QM_IDX_W'(off >> sh);
        end
    end

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int r = NUM_REG - 1; r >= 0; r--) begin
            if (match[r]) begin
                hit = 1'b1;
                idx = ridx[r];
            end
        end
    end
endmodule

// File: rtl/qm_addr_dec.sv
module qm_addr_dec
    import qm_pkg::*;
#(
    parameter int NUM_REG = 4
) (
    input  qm_region_t [NUM_REG-1:0] rgn,
    input  logic [QM_IDX_W-1:0]      idx,
    output logic [QM_ADDR_W-1:0]     addr
);
    localparam int RW = QM_IDX_W + 1;

    logic [NUM_REG-1:0]                inr;
    logic [NUM_REG-1:0][QM_ADDR_W-1:0] raddr;

    for (genvar r = 0; r < NUM_REG; r++) begin : g_rgn
        logic [RW-1:0] rel;
        logic [4:0]    sh;
        always_comb begin
            sh  = 5'(rgn[r].sz_log2) + 5'd4;
            rel = {1'b0, idx} - {1'b0, rgn[r].start};
            inr[r]   = rgn[r].vld && (idx >= rgn[r].start)
                       && (rel < (RW'(1) << rgn[r].cnt_log2));
            raddr[r] = rgn[r].base + (QM_ADDR_W'(rel) << sh);
        end
    end

    always_comb begin
        addr = '0;
        for (int r = NUM_REG - 1; r >= 0; r--) begin
            if (inr[r]) addr = raddr[r];
        end
    end
endmodule

// File: rtl/qm_queue_mgr.sv
module qm_queue_mgr
    import qm_pkg::*;
#(
    parameter int NUM_Q   = 64,
    parameter int NUM_REG = 4,
    localparam int QSEL_W = $clog2(NUM_Q),
    localparam int RSEL_W = $clog2(NUM_REG),
    localparam int CNT_W  = QM_IDX_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [RSEL_W-1:0]    cfg_sel,
    input  logic [QM_ADDR_W-1:0] cfg_base,
    input  logic [QM_IDX_W-1:0]  cfg_start,
    input  logic [QM_SZ_W-1:0]   cfg_size_log2,
    input  logic [QM_CL_W-1:0]   cfg_count_log2,
    input  logic                 push_en,
    input  logic [QSEL_W-1:0]    push_queue,
    input  logic [QM_ADDR_W-1:0] push_addr,
    input  logic                 pop_en,
    input  logic [QSEL_W-1:0]    pop_queue,
    output logic                 pop_valid,
    output logic [QM_ADDR_W-1:0] pop_addr,
    input  logic [QSEL_W-1:0]    cnt_queue,
    output logic [CNT_W-1:0]     cnt_value,
    output logic [NUM_Q-1:0]     q_pending,
    output logic                 push_err
);
    localparam int LINK_DEPTH = 1 << QM_IDX_W;

    typedef struct packed {
        qm_region_t [NUM_REG-1:0]           rgn;
        logic [NUM_Q-1:0][QM_IDX_W-1:0]     head;
        logic [NUM_Q-1:0][QM_IDX_W-1:0]     tail;
        logic [NUM_Q-1:0][CNT_W-1:0]        cnt;
        logic                               err;
        logic                               pvld;
        logic [QM_ADDR_W-1:0]               paddr;
    } qm_state_t;

    qm_state_t state_q, state_d;

    logic                 enc_hit;
    logic [QM_IDX_W-1:0]  enc_idx;
    logic [QM_ADDR_W-1:0] dec_addr;
    logic [QM_IDX_W-1:0]  link_rdata;
    logic                 push_ok, same_q, cfg_ok;
    logic [CNT_W-1:0]     pop_cnt_eff;
    logic [QM_IDX_W-1:0]  pop_idx_d, pop_next_d;

    qm_addr_enc #(.NUM_REG(NUM_REG)) u_enc (
        .rgn  (state_q.rgn),
        .addr (push_addr),
        .hit  (enc_hit),
        .idx  (enc_idx)
    );

    qm_addr_dec #(.NUM_REG(NUM_REG)) u_dec (
        .rgn  (state_q.rgn),
        .idx  (pop_idx_d),
        .addr (dec_addr)
    );

    qm_link_ram #(.DEPTH(LINK_DEPTH), .W(QM_IDX_W)) u_link (
        .clk   (clk),
        .we    (push_ok && (state_q.cnt[push_queue] != '0)),
        .waddr (state_q.tail[push_queue]),
        .wdata (enc_idx),
        .raddr (state_q.head[pop_queue]),
        .rdata (link_rdata)
    );

    // Push-first view of the popped queue
    always_comb begin
        push_ok     = push_en && enc_hit;
        same_q      = push_ok && (push_queue == pop_queue);
        pop_cnt_eff = state_q.cnt[pop_queue] + CNT_W'(same_q);
        pop_idx_d   = (same_q && state_q.cnt[pop_queue] == '0) ? enc_idx
                                                                 : state_q.head[pop_queue];
        pop_next_d  = (same_q && state_q.cnt[pop_queue] == CNT_W'(1)) ? enc_idx
                                                                        : link_rdata;
        cfg_ok      = (cfg_base[3:0] == 4'd0) && (cfg_size_log2 != '0)
                      && (cfg_count_log2 >= QM_CL_W'(QM_CL_MIN))
                      && (cfg_count_log2 <= QM_CL_W'(QM_IDX_W));
    end

    always_comb begin
        state_d      = state_q;
        state_d.pvld = 1'b0;

        if (cfg_we && cfg_ok) begin
            state_d.rgn[cfg_sel].vld      = 1'b1;
            state_d.rgn[cfg_sel].base     = cfg_base;
            state_d.rgn[cfg_sel].start    = cfg_start;
            state_d.rgn[cfg_sel].sz_log2  = cfg_size_log2;
            state_d.rgn[cfg_sel].cnt_log2 = cfg_count_log2;
        end

        if (push_en && !enc_hit) state_d.err = 1'b1;

        if (push_ok) begin
            if (state_q.cnt[push_queue] == '0) state_d.head[push_queue] = enc_idx;
            state_d.tail[push_queue] = enc_idx;
            state_d.cnt[push_queue]  = state_q.cnt[push_queue] + CNT_W'(1);
        end

        if (pop_en) begin
            state_d.pvld = 1'b1;
            if (pop_cnt_eff == '0) begin
                state_d.paddr = '0;
            end else begin
                state_d.paddr           = dec_addr;
                state_d.head[pop_queue] = pop_next_d;
                state_d.cnt[pop_queue]  = pop_cnt_eff - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    for (genvar n = 0; n < NUM_Q; n++) begin : g_pend
        assign q_pending[n] = |state_q.cnt[n];
    end

    assign cnt_value = state_q.cnt[cnt_queue];
    assign pop_valid = state_q.pvld;
    assign pop_addr  = state_q.paddr;
    assign push_err  = state_q.err;
endmodule

// File: rtl/qm_queue_mgr_chk.sv
module qm_queue_mgr_chk #(
    parameter int NUM_Q  = 64,
    parameter int QSEL_W = 6,
    parameter int CNT_W  = 9,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push_en,
    input logic [QSEL_W-1:0] push_queue,
    input logic              pop_en,
    input logic [QSEL_W-1:0] pop_queue,
    input logic [QSEL_W-1:0] cnt_queue,
    input logic [CNT_W-1:0]  cnt_value,
    input logic [NUM_Q-1:0]  q_pending,
    input logic              pop_valid,
    input logic [ADDR_W-1:0] pop_addr,
    input logic              push_err
);
    p_pend_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q_pending[cnt_queue] == (cnt_value != '0));

    p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        push_err |=> push_err);

    p_pop_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pop_en |=> pop_valid);

    p_no_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_en |=> !pop_valid);

    p_empty_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_en && !push_en && pop_queue == cnt_queue && cnt_value == '0)
        |=> (pop_valid && pop_addr == '0));

    p_idle_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_en && !pop_en)
        |=> (cnt_queue != $past(cnt_queue)) || (cnt_value == $past(cnt_value)));

    p_push_grow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && !pop_en && push_queue == cnt_queue && !push_err)
        |=> push_err || (cnt_queue != $past(cnt_queue))
            || (cnt_value == $past(cnt_value) + CNT_W'(1)));
endmodule

bind qm_queue_mgr qm_queue_mgr_chk #(
    .NUM_Q (NUM_Q),
    .QSEL_W(QSEL_W),
    .CNT_W (CNT_W),
    .ADDR_W(qm_pkg::QM_ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_en   (push_en),
    .push_queue(push_queue),
    .pop_en    (pop_en),
    .pop_queue (pop_queue),
    .cnt_queue (cnt_queue),
    .cnt_value (cnt_value),
    .q_pending (q_pending),
    .pop_valid (pop_valid),
    .pop_addr  (pop_addr),
    .push_err  (push_err)
);

// File: tb/sim_qm_queue_mgr.sv
module sim_qm_queue_mgr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_base = '0;
    logic [7:0]  cfg_start = '0;
    logic [2:0]  cfg_size_log2 = '0;
    logic [3:0]  cfg_count_log2 = '0;
    logic        push_en = 1'b0;
    logic [5:0]  push_queue = '0;
    logic [31:0] push_addr = '0;
    logic        pop_en = 1'b0;
    logic [5:0]  pop_queue = '0;
    logic        pop_valid;
    logic [31:0] pop_addr;
    logic [5:0]  cnt_queue = '0;
    logic [8:0]  cnt_value;
    logic [63:0] q_pending;
    logic        push_err;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    qm_queue_mgr u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_base(cfg_base),
        .cfg_start(cfg_start), .cfg_size_log2(cfg_size_log2),
        .cfg_count_log2(cfg_count_log2),
        .push_en(push_en), .push_queue(push_queue), .push_addr(push_addr),
        .pop_en(pop_en), .pop_queue(pop_queue),
        .pop_valid(pop_valid), .pop_addr(pop_addr),
        .cnt_queue(cnt_queue), .cnt_value(cnt_value),
        .q_pending(q_pending), .push_err(push_err)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h, expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic cfg(input logic [1:0] r, input logic [31:0] b, input logic [7:0] s,
                       input logic [2:0] sz, input logic [3:0] cl);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = r; cfg_base = b; cfg_start = s;
        cfg_size_log2 = sz; cfg_count_log2 = cl;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic push(input logic [5:0] q, input logic [31:0] a);
        @(negedge clk);
        push_en = 1'b1; push_queue = q; push_addr = a;
        @(negedge clk);
        push_en = 1'b0;
    endtask

    task automatic pop(input logic [5:0] q, output logic v, output logic [31:0] a);
        @(negedge clk);
        pop_en = 1'b1; pop_queue = q;
        @(negedge clk);
        pop_en = 1'b0;
        v = pop_valid; a = pop_addr;
    endtask

    task automatic pushpop(input logic [5:0] q, input logic [31:0] pa, output logic [31:0] a);
        @(negedge clk);
        push_en = 1'b1; push_queue = q; push_addr = pa;
        pop_en = 1'b1; pop_queue = q;
        @(negedge clk);
        push_en = 1'b0; pop_en = 1'b0;
        a = pop_addr;
    endtask

    task automatic count_of(input logic [5:0] q, output logic [8:0] c);
        cnt_queue = q;
        #1;
        c = cnt_value;
    endtask

    task automatic std_regions();
        cfg(2'd0, 32'h1000_0000, 8'd0, 3'd2, 4'd5);
        cfg(2'd1, 32'h2000_0000, 8'd32, 3'd1, 4'd6);
    endtask

    task automatic t_reset();
        logic [8:0] c;
        do_reset();
        count_of(6'd0, c);
        check("R1 count", c, 0);
        check("R1 pending", q_pending, 0);
        check("R1 err", push_err, 0);
        check("R1 pop_valid", pop_valid, 0);
        push(6'd1, 32'h1000_0000);
        check("R1 no region push rejected", push_err, 1);
    endtask

    task automatic t_fifo();
        logic v; logic [31:0] a; logic [8:0] c;
        do_reset();
        std_regions();
        push(6'd3, 32'h1000_0080);
        push(6'd7, 32'h2000_07E0);
        push(6'd3, 32'h2000_00A0);
        push(6'd3, 32'h1000_0000);
        count_of(6'd3, c); check("R3 count q3", c, 3);
        count_of(6'd7, c); check("R8 count q7", c, 1);
        check("R7 pending", q_pending, (64'd1 << 3) | (64'd1 << 7));
        check("R3 err clear", push_err, 0);
        pop(6'd3, v, a); check("R5 valid", v, 1); check("R10 first", a, 32'h1000_0080);
        count_of(6'd3, c); check("R5 count dec", c, 2);
        pop(6'd7, v, a); check("R10 other queue", a, 32'h2000_07E0);
        pop(6'd3, v, a); check("R10 second", a, 32'h2000_00A0);
        pop(6'd3, v, a); check("R10 third", a, 32'h1000_0000);
        check("R7 pending cleared", q_pending, 0);
        @(negedge clk);
        check("R5 one-cycle valid", pop_valid, 0);
    endtask

    task automatic t_empty_pop();
        logic v; logic [31:0] a; logic [8:0] c;
        push(6'd3, 32'h1000_0040);
        pop(6'd5, v, a);
        check("R6 valid", v, 1);
        check("R6 addr zero", a, 0);
        count_of(6'd5, c); check("R6 count q5", c, 0);
        count_of(6'd3, c); check("R6 q3 untouched", c, 1);
        pop(6'd3, v, a); check("R6 q3 still ok", a, 32'h1000_0040);
    endtask

    task automatic t_bad_push();
        logic [8:0] c;
        push(6'd1, 32'h1000_0020);
        check("R4 misaligned err", push_err, 1);
        count_of(6'd1, c); check("R4 misaligned dropped", c, 0);
        push(6'd1, 32'h1000_0800);
        count_of(6'd1, c); check("R4 out of range dropped", c, 0);
        repeat (4) @(negedge clk);
        check("R4 sticky", push_err, 1);
        check("R4 pending", q_pending, 0);
    endtask

    task automatic t_cfg();
        logic v; logic [31:0] a;
        do_reset();
        cfg(2'd2, 32'h3000_0008, 8'd96, 3'd3, 4'd5);
        cfg(2'd2, 32'h3000_0000, 8'd96, 3'd0, 4'd5);
        cfg(2'd2, 32'h3000_0000, 8'd96, 3'd3, 4'd9);
        cfg(2'd2, 32'h3000_0000, 8'd96, 3'd3, 4'd4);
        push(6'd2, 32'h3000_0200);
        check("R2 illegal writes ignored", push_err, 1);
        check("R2 no entry", q_pending, 0);
        do_reset();
        cfg(2'd2, 32'h3000_0000, 8'd96, 3'd3, 4'd5);
        push(6'd2, 32'h3000_0200);
        check("R2 legal accepted", push_err, 0);
        pop(6'd2, v, a);
        check("R2 round trip", a, 32'h3000_0200);
    endtask

    task automatic t_same_cycle();
        logic v; logic [31:0] a; logic [8:0] c;
        do_reset();
        std_regions();
        pushpop(6'd4, 32'h2000_0020, a);
        check("R9 empty returns pushed", a, 32'h2000_0020);
        count_of(6'd4, c); check("R9 empty stays empty", c, 0);
        push(6'd4, 32'h1000_00C0);
        pushpop(6'd4, 32'h2000_0040, a);
        check("R9 one entry returns old", a, 32'h1000_00C0);
        count_of(6'd4, c); check("R9 count stays 1", c, 1);
        pop(6'd4, v, a);
        check("R9 pushed follows", a, 32'h2000_0040);
        count_of(6'd4, c); check("R9 drained", c, 0);
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_fifo();
        t_empty_pop();
        t_bad_push();
        t_cfg();
        t_same_cycle();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule